// File: doc/BRIEF.md
# Indirect Configuration Register Block with Keyed Soft Reset

This block sits between a host's narrow parallel bus and the serial bus engine of a controller. A 2-bit address selects one of four direct locations. Direct location 0 is an index pointer. Direct location 1 is a data window that reaches whichever indirect register the pointer currently selects. The indirect registers hold the serial clock low-phase count, the serial clock high-phase count, the bus timeout and the operating mode. They drive the engine continuously as configuration outputs.

Indirect index 5 is a write-only key port. The host writes A5h and then 5Ah to it. The block then issues a single-cycle soft reset to the rest of the controller. The same pulse restores this block's own configuration and pointer to their defaults. Any other access between the two key bytes cancels the unlock. A stray write therefore cannot reset the controller.

Reads return data one clock after the read strobe, and the read data holds between reads.

Top module: `ireg_host_regs`

## Requirements
- R1: After the synchronous reset, the outputs are as follows: rdata is 00h, soft_rst is 0 and the pointer reads 0. The configuration outputs hold their defaults: scl_lo 9Dh, scl_hi 86h, timeout FFh and mode 00h.
- R2: A write to direct address 0 stores the low 3 bits of wdata as the pointer. A read of address 0 returns the pointer zero-extended to 8 bits.
- R3: A write to direct address 1 updates the indirect register selected by the pointer: index 2 is scl_lo, 3 is scl_hi, 4 is timeout and 6 is mode. The matching output changes after that clock edge. A read of address 1 at those indices returns the stored value.
- R4: Indirect indices 0, 1, 5 and 7 read as 00h. Writes to indices 0, 1 and 7 change no configuration output.
- R5: Direct addresses 2 and 3 read as 00h. Writes to them change neither the pointer nor any configuration output.
- R6: Two window writes at index 5 fire the soft reset. The first writes A5h and the second writes 5Ah, with idle cycles allowed between them. soft_rst is then high for exactly one cycle, namely the cycle after the 5Ah write's clock edge.
- R7: Certain accesses between A5h and 5Ah cancel the unlock. These are any read, any write to another address or index, and any key byte other than A5h or 5Ah. A repeated A5h re-arms the unlock.
- R8: The clock edge that raises soft_rst restores all configuration outputs to their defaults and clears the pointer to 0.
- R9: A 5Ah key write that is not preceded by an armed A5h produces no pulse.
- R10: rdata keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Direct location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | One-cycle soft reset pulse to the controller |
| scl_lo | output | 8 | Clock low-phase count |
| scl_hi | output | 8 | Clock high-phase count |
| timeout | output | 8 | Bus timeout setting |
| mode | output | 8 | Operating mode setting |

## Verification
The hardest situation to reach is an armed unlock that a single intervening access has to cancel. The stimulus arms the port with A5h and then inserts one disturbing access before sending 5Ah. The disturbing access is a read, a pointer rewrite or a wrong key byte. A monitor counts every soft reset pulse, so an unwanted pulse is seen even when no read follows. The positive case leaves idle cycles between the key bytes and puts a doubled A5h before 5Ah. Non-default settings are loaded first, so the restore on the pulse is visible at the configuration outputs.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int IDX_W = 3;

  localparam logic [1:0] DIR_PTR = 2'd0;
  localparam logic [1:0] DIR_WIN = 2'd1;

  localparam logic [IDX_W-1:0] IDX_SCL_LO = 3'd2;
  localparam logic [IDX_W-1:0] IDX_SCL_HI = 3'd3;
  localparam logic [IDX_W-1:0] IDX_TMO    = 3'd4;
  localparam logic [IDX_W-1:0] IDX_KEY    = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MODE   = 3'd6;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  typedef enum logic {
    UNL_IDLE,
    UNL_ARMED
  } unl_state_t;
endpackage

// File: rtl/ireg_cfg_bank.sv
module ireg_cfg_bank #(
  parameter int DW    = 8,
  parameter int N_CFG = 4,
  parameter logic [N_CFG*ireg_pkg::IDX_W-1:0] SLOT_IDX = '0,
  parameter logic [N_CFG*DW-1:0]              SLOT_DEF = '0
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      win_wr,
  input  logic [ireg_pkg::IDX_W-1:0] ptr,
  input  logic [DW-1:0]             wdata,
  output logic [N_CFG*DW-1:0]       cfg_q
);
  localparam int IW = ireg_pkg::IDX_W;

  for (genvar g = 0; g < N_CFG; g++) begin : g_slot
    localparam logic [IW-1:0] MY_IDX = SLOT_IDX[g*IW +: IW];
    localparam logic [DW-1:0] MY_DEF = SLOT_DEF[g*DW +: DW];
    logic hit;
    assign hit = win_wr && (ptr == MY_IDX);
    always_ff @(posedge clk) begin
      if (clr)      cfg_q[g*DW +: DW] <= MY_DEF;
      else if (hit) cfg_q[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/ireg_unlock.sv
module ireg_unlock #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_acc,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          fire,
  output logic          pulse_q
);
  import ireg_pkg::*;

  unl_state_t st_q, st_d;
  logic is_first, is_second;

  assign is_first  = (wdata == DW'(KEY_FIRST));
  assign is_second = (wdata == DW'(KEY_SECOND));
  assign fire      = (st_q == UNL_ARMED) && key_wr && is_second;

  always_comb begin
    st_d = st_q;
    if (fire)                     st_d = UNL_IDLE;
    else if (key_wr && is_first)  st_d = UNL_ARMED;
    else if (any_acc)             st_d = UNL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= UNL_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= fire;
    end
  end
endmodule

// File: rtl/ireg_rdmux.sv
module ireg_rdmux #(
  parameter int DW    = 8,
  parameter int N_CFG = 4,
  parameter logic [N_CFG*ireg_pkg::IDX_W-1:0] SLOT_IDX = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [1:0]                addr,
  input  logic [ireg_pkg::IDX_W-1:0] ptr,
  input  logic [N_CFG*DW-1:0]       cfg_q,
  output logic [DW-1:0]             rdata
);
  import ireg_pkg::*;

  logic [DW-1:0] win_val, sel_val;

  always_comb begin
    win_val = '0;
    for (int i = 0; i < N_CFG; i++) begin
      if (ptr == SLOT_IDX[i*IDX_W +: IDX_W]) win_val = cfg_q[i*DW +: DW];
    end
  end

  always_comb begin
    case (addr)
      DIR_PTR: sel_val = DW'(ptr);
      DIR_WIN: sel_val = win_val;
      default: sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_val;
  end
endmodule

// File: rtl/ireg_host_regs.sv
module ireg_host_regs #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] DEF_SCL_LO = 8'h9D,
  parameter logic [DW-1:0] DEF_SCL_HI = 8'h86,
  parameter logic [DW-1:0] DEF_TMO    = 8'hFF,
  parameter logic [DW-1:0] DEF_MODE   = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          soft_rst,
  output logic [DW-1:0] scl_lo,
  output logic [DW-1:0] scl_hi,
  output logic [DW-1:0] timeout,
  output logic [DW-1:0] mode
);
  import ireg_pkg::*;

  localparam int N_CFG = 4;
  localparam logic [N_CFG*IDX_W-1:0] SLOT_IDX =
    {IDX_MODE, IDX_TMO, IDX_SCL_HI, IDX_SCL_LO};
  localparam logic [N_CFG*DW-1:0] SLOT_DEF =
    {DEF_MODE, DEF_TMO, DEF_SCL_HI, DEF_SCL_LO};

  logic [IDX_W-1:0]    ptr_q;
  logic                win_wr, ptr_wr, key_wr, any_acc, fire, clr;
  logic [N_CFG*DW-1:0] cfg_q;

  assign ptr_wr  = wr_en && (addr == DIR_PTR);
  assign win_wr  = wr_en && (addr == DIR_WIN);
  assign key_wr  = win_wr && (ptr_q == IDX_KEY);
  assign any_acc = wr_en || rd_en;
  assign clr     = rst || fire;

  always_ff @(posedge clk) begin
    if (clr)         ptr_q <= '0;
    else if (ptr_wr) ptr_q <= wdata[IDX_W-1:0];
  end

  ireg_unlock #(.DW(DW)) u_unlock (
    .clk     (clk),
    .rst     (rst),
    .any_acc (any_acc),
    .key_wr  (key_wr),
    .wdata   (wdata),
    .fire    (fire),
    .pulse_q (soft_rst)
  );

  ireg_cfg_bank #(
    .DW(DW), .N_CFG(N_CFG), .SLOT_IDX(SLOT_IDX), .SLOT_DEF(SLOT_DEF)
  ) u_bank (
    .clk    (clk),
    .clr    (clr),
    .win_wr (win_wr),
    .ptr    (ptr_q),
    .wdata  (wdata),
    .cfg_q  (cfg_q)
  );

  ireg_rdmux #(
    .DW(DW), .N_CFG(N_CFG), .SLOT_IDX(SLOT_IDX)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .ptr   (ptr_q),
    .cfg_q (cfg_q),
    .rdata (rdata)
  );

  assign scl_lo  = cfg_q[0*DW +: DW];
  assign scl_hi  = cfg_q[1*DW +: DW];
  assign timeout = cfg_q[2*DW +: DW];
  assign mode    = cfg_q[3*DW +: DW];
endmodule

// File: rtl/ireg_host_regs_chk.sv
module ireg_host_regs_chk #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] DEF_SCL_LO = 8'h9D,
  parameter logic [DW-1:0] DEF_SCL_HI = 8'h86,
  parameter logic [DW-1:0] DEF_TMO    = 8'hFF,
  parameter logic [DW-1:0] DEF_MODE   = 8'h00
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          soft_rst,
  input logic [DW-1:0] scl_lo,
  input logic [DW-1:0] scl_hi,
  input logic [DW-1:0] timeout,
  input logic [DW-1:0] mode
);
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> $past(wr_en && addr == 2'd1 && wdata == DW'(8'h5A)));

  p_restore_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (scl_lo == DEF_SCL_LO && scl_hi == DEF_SCL_HI &&
                  timeout == DEF_TMO && mode == DEF_MODE));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(scl_lo) && $stable(scl_hi) &&
                $stable(timeout) && $stable(mode)));
endmodule

bind ireg_host_regs ireg_host_regs_chk #(
  .DW(DW), .DEF_SCL_LO(DEF_SCL_LO), .DEF_SCL_HI(DEF_SCL_HI),
  .DEF_TMO(DEF_TMO), .DEF_MODE(DEF_MODE)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .soft_rst(soft_rst), .scl_lo(scl_lo),
  .scl_hi(scl_hi), .timeout(timeout), .mode(mode)
);

// File: tb/sim_ireg_host_regs.sv
`timescale 1ns/1ps
module sim_ireg_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, scl_lo, scl_hi, timeout, mode;
  logic       soft_rst;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ireg_host_regs u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .soft_rst(soft_rst), .scl_lo(scl_lo),
    .scl_hi(scl_hi), .timeout(timeout), .mode(mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic check_cfg(input string tag, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] to, input logic [7:0] md);
    check({tag, " scl_lo"}, scl_lo, lo);
    check({tag, " scl_hi"}, scl_hi, hi);
    check({tag, " timeout"}, timeout, to);
    check({tag, " mode"}, mode, md);
  endtask

  // scoreboard monitor: read data lands after the edge that samples rd_en
  always @(posedge clk) begin
    if (rd_en && !rst) begin
      #2;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %02h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  always @(negedge clk) if (!rst && soft_rst) pulses <= pulses + 1;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 rdata", rdata, 8'h00);
    check("R1 soft_rst", {7'd0, soft_rst}, 8'h00);
    check_cfg("R1", 8'h9D, 8'h86, 8'hFF, 8'h00);
    rd(2'd0, 8'h00, "R1 pointer");
    // R2
    wr(2'd0, 8'hFB);
    rd(2'd0, 8'h03, "R2 pointer low bits");
    // R3
    wr(2'd0, 8'd2); wr(2'd1, 8'h11);
    wr(2'd0, 8'd3); wr(2'd1, 8'h22);
    wr(2'd0, 8'd4); wr(2'd1, 8'h33);
    wr(2'd0, 8'd6); wr(2'd1, 8'h44);
    check_cfg("R3", 8'h11, 8'h22, 8'h33, 8'h44);
    wr(2'd0, 8'd2); rd(2'd1, 8'h11, "R3 read scl_lo");
    wr(2'd0, 8'd3); rd(2'd1, 8'h22, "R3 read scl_hi");
    wr(2'd0, 8'd4); rd(2'd1, 8'h33, "R3 read timeout");
    wr(2'd0, 8'd6); rd(2'd1, 8'h44, "R3 read mode");
    // R10
    repeat (3) @(negedge clk);
    check("R10 rdata hold", rdata, 8'h44);
    // R4
    wr(2'd0, 8'd0); wr(2'd1, 8'h77); rd(2'd1, 8'h00, "R4 index0");
    wr(2'd0, 8'd1); wr(2'd1, 8'h77); rd(2'd1, 8'h00, "R4 index1");
    wr(2'd0, 8'd7); wr(2'd1, 8'h77); rd(2'd1, 8'h00, "R4 index7");
    wr(2'd0, 8'd5); rd(2'd1, 8'h00, "R4 key port reads zero");
    check_cfg("R4", 8'h11, 8'h22, 8'h33, 8'h44);
    // R5
    wr(2'd2, 8'h99); wr(2'd3, 8'h99);
    rd(2'd2, 8'h00, "R5 addr2");
    rd(2'd3, 8'h00, "R5 addr3");
    rd(2'd0, 8'h05, "R5 pointer untouched");
    check_cfg("R5", 8'h11, 8'h22, 8'h33, 8'h44);
    // R9
    p0 = pulses;
    wr(2'd1, 8'h5A);
    repeat (2) @(negedge clk);
    check("R9 lone second key", 8'(pulses - p0), 8'd0);
    // R7 cancellations
    wr(2'd1, 8'hA5); rd(2'd1, 8'h00, "R7 read between"); wr(2'd1, 8'h5A);
    wr(2'd1, 8'hA5); wr(2'd0, 8'd5); wr(2'd1, 8'h5A);
    wr(2'd1, 8'hA5); wr(2'd1, 8'h5B); wr(2'd1, 8'h5A);
    repeat (2) @(negedge clk);
    check("R7 cancelled unlocks", 8'(pulses - p0), 8'd0);
    check_cfg("R7", 8'h11, 8'h22, 8'h33, 8'h44);
    // R6 with idle gap
    wr(2'd1, 8'hA5);
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h5A);
    check("R6 pulse high", {7'd0, soft_rst}, 8'h01);
    // R8
    check_cfg("R8", 8'h9D, 8'h86, 8'hFF, 8'h00);
    @(negedge clk);
    check("R6 pulse low", {7'd0, soft_rst}, 8'h00);
    check("R6 one pulse", 8'(pulses - p0), 8'd1);
    rd(2'd0, 8'h00, "R8 pointer cleared");
    // R7 re-arm with doubled first key
    wr(2'd0, 8'd2); wr(2'd1, 8'h12);
    wr(2'd0, 8'd5);
    wr(2'd1, 8'hA5); wr(2'd1, 8'hA5); wr(2'd1, 8'h5A);
    check("R7 rearm pulse", {7'd0, soft_rst}, 8'h01);
    check("R8 scl_lo restored", scl_lo, 8'h9D);
    repeat (3) @(negedge clk);
    check("R7 pulse count", 8'(pulses - p0), 8'd2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule